// File: doc/BRIEF.md
# Parallel LCD command/data bus controller

This block drives one or two external display panels that sit on a shared 16-bit parallel bus. Software talks to it through a small 32-bit register bus: a write to the command register puts one word on the panel bus with the A0 line low, a write to the parameter register puts one word with A0 high, and a write to the pixel data register puts two A0-high words, the low half first. Each panel has its own select strobe, and a two-bit panel mask in the control register decides which panels see a write. Either panel may be the target of a single-word read, whose result lands in a receive buffer that software reads back.

A transfer is opened by a go bit in the control register, which raises a busy flag if the pixel counter is nonzero and the start conditions hold. Every pixel write and every panel read counts the counter down; when it reaches zero during a transfer, busy drops and a one-cycle frame-done pulse is raised. Every panel word is framed by one setup cycle, one strobe cycle and one hold cycle, and a register-bus write that touches the panel is held off with `bus_ready` low until its last word has been framed.

Top module: `lcd_pbus_ctrl`

## Requirements
- R1: After reset the control register reads 0x2 (bypass set), both configuration registers read 0x00310000, the pixel counter and the receive buffer read 0, the system status register reads 0x1, and no select strobe or frame-done pulse is active.
- R2: Register writes keep only their defined bits: control keeps bits 3:0 (bit 0 enable, bit 1 bypass, bit 2 panel 0, bit 3 panel 1; bit 4 is a write-only go bit), configuration 0x003F1FFF, on/off time 0x3FFFFFFF, cycle time 0x0FFFFFFF, the six data-cycle registers 0x0F1F0F1F, the two sync widths 0xFFFF, line number 0x7FF, pixel counter the low 24 bits.
- R3: A command write (offset 0x10) sends bits 15:0 as one panel word with A0 low, strobing every panel whose mask bit is set, all in the same cycle.
- R4: A parameter write (offset 0x14) sends bits 15:0 as one panel word with A0 high to every selected panel.
- R5: A pixel data write (offset 0x18) sends bits 15:0 and then bits 31:16, both with A0 high, to every selected panel, and then counts the pixel counter down by one.
- R6: A write to the data-read trigger (0x1C) or status-read trigger (0x20) performs one panel read with A0 high or low respectively, from panel 0 when its mask bit is set and otherwise from panel 1, latches the 16 bits into the receive buffer (read at 0x1C or 0x20), and counts the pixel counter down; with no panel selected the buffer keeps its value. The counter never goes below zero.
- R7: The system status register (0x00) reads bit 0 as 1 and bit 8 as the busy flag.
- R8: A control write with bit 4 set starts a transfer only if the written value has enable set and bypass clear, the AND of the two configuration registers has neither bit 3 nor bit 2 set, and the block is not busy.
- R9: When the pixel counter steps from 1 to 0 while busy, busy clears and `frame_done` is high for exactly one cycle.
- R10: A start request with the pixel counter at zero leaves busy low and raises no frame-done pulse.
- R11: Panel data and A0 hold their value for one cycle before and one cycle after the select strobe, and the strobe lasts one cycle.
- R12: A panel-bound register write keeps `bus_ready` low for 3 cycles per panel word (6 for a pixel write) before completing; any other register access completes with `bus_ready` high at once.
- R13: Reads of unmapped offsets return 0, and writes to the system status register change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request, held until `bus_ready` |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is selected |
| bus_ready | output | 1 | Access completes at the clock edge where this is high |
| pnl_dout | output | PANEL_W | Panel bus word being written or framed |
| pnl_din | input | PANEL_W | Panel bus word returned during a read strobe |
| pnl_a0 | output | 1 | 0 = command/status word, 1 = data/parameter word |
| pnl_cs | output | 2 | Per-panel select strobes |
| pnl_wr | output | 1 | Write strobe |
| pnl_rd | output | 1 | Read strobe |
| frame_done | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
Register effects appear at the edge that completes the access, so read-backs and the busy flag are sampled at the falling edge right after the write completes. A panel word reaches the strobe two edges after its access is launched and is logged at falling edges, where the bench also compares the bus word with the cycle before and after the strobe. The completion pulse is due in the cycle that follows the finishing edge of the last counted access and is checked there and one cycle later, while the ready wait is counted in falling edges so that the 3- and 6-cycle stalls are checked exactly.

// File: rtl/lcd_pbus_pkg.sv
package lcd_pbus_pkg;

   localparam int REG_W   = 32;
   localparam int N_PANEL = 2;
   localparam int N_DCYC  = 6;

   // register offsets (byte addresses)
   localparam logic [7:0] OFS_SYSST  = 8'h00;
   localparam logic [7:0] OFS_CTRL   = 8'h04;
   localparam logic [7:0] OFS_PIXCNT = 8'h08;
   localparam logic [7:0] OFS_LINE   = 8'h0C;
   localparam logic [7:0] OFS_CMD    = 8'h10;
   localparam logic [7:0] OFS_PARM   = 8'h14;
   localparam logic [7:0] OFS_PIX    = 8'h18;
   localparam logic [7:0] OFS_RDDAT  = 8'h1C;
   localparam logic [7:0] OFS_RDSTS  = 8'h20;
   localparam logic [7:0] OFS_CFG0   = 8'h24;
   localparam logic [7:0] OFS_CFG1   = 8'h28;
   localparam logic [7:0] OFS_ONOFF0 = 8'h2C;
   localparam logic [7:0] OFS_CYC0   = 8'h30;
   localparam logic [7:0] OFS_ONOFF1 = 8'h34;
   localparam logic [7:0] OFS_CYC1   = 8'h38;
   localparam logic [7:0] OFS_DCYC   = 8'h3C;
   localparam logic [7:0] OFS_VSW    = 8'h54;
   localparam logic [7:0] OFS_HSW    = 8'h58;

   // field masks and reset values
   localparam logic [31:0] MSK_CFG   = 32'h003F_1FFF;
   localparam logic [31:0] RST_CFG   = 32'h0031_0000;
   localparam logic [31:0] MSK_ONOFF = 32'h3FFF_FFFF;
   localparam logic [31:0] MSK_CYC   = 32'h0FFF_FFFF;
   localparam logic [31:0] MSK_DCYC  = 32'h0F1F_0F1F;
   localparam logic [31:0] MSK_SYNC  = 32'h0000_FFFF;
   localparam logic [31:0] MSK_LINE  = 32'h0000_07FF;
   localparam logic [3:0]  RST_CTRL  = 4'h2;

   // control bit positions
   localparam int CB_EN   = 0;
   localparam int CB_BYP  = 1;
   localparam int CB_SEL0 = 2;
   localparam int CB_SEL1 = 3;
   localparam int CB_GO   = 4;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_SETUP,
      SQ_STRB,
      SQ_HOLD
   } sq_state_e;

   typedef enum logic [2:0] {
      POP_NONE,
      POP_CMD,
      POP_PARM,
      POP_PIX,
      POP_RDD,
      POP_RDS
   } pop_e;

endpackage

// File: rtl/lcd_pbus_regs.sv
module lcd_pbus_regs
   import lcd_pbus_pkg::*;
#(
   parameter int CNT_W   = 24,
   parameter int PANEL_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [7:0]         addr,
   input  logic [REG_W-1:0]   wdata,
   input  logic               busy,
   input  logic [CNT_W-1:0]   cnt,
   input  logic [PANEL_W-1:0] rxbuf,
   output logic [1:0]         sel_mask,
   output logic               cfg_go_ok,
   output logic [REG_W-1:0]   rdata
);

   logic [3:0]       ctrl_q;
   logic [REG_W-1:0] cfg0_q, cfg1_q;
   logic [REG_W-1:0] onoff0_q, onoff1_q, cyc0_q, cyc1_q;
   logic [REG_W-1:0] vsw_q, hsw_q, line_q;
   logic [REG_W-1:0] dcyc_q [N_DCYC];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= RST_CTRL;
         cfg0_q   <= RST_CFG;
         cfg1_q   <= RST_CFG;
         onoff0_q <= '0;
         onoff1_q <= '0;
         cyc0_q   <= '0;
         cyc1_q   <= '0;
         vsw_q    <= '0;
         hsw_q    <= '0;
         line_q   <= '0;
      end else if (wr_en) begin
         case (addr)
            OFS_CTRL:   ctrl_q   <= wdata[3:0];
            OFS_CFG0:   cfg0_q   <= wdata & MSK_CFG;
            OFS_CFG1:   cfg1_q   <= wdata & MSK_CFG;
            OFS_ONOFF0: onoff0_q <= wdata & MSK_ONOFF;
            OFS_ONOFF1: onoff1_q <= wdata & MSK_ONOFF;
            OFS_CYC0:   cyc0_q   <= wdata & MSK_CYC;
            OFS_CYC1:   cyc1_q   <= wdata & MSK_CYC;
            OFS_VSW:    vsw_q    <= wdata & MSK_SYNC;
            OFS_HSW:    hsw_q    <= wdata & MSK_SYNC;
            OFS_LINE:   line_q   <= wdata & MSK_LINE;
            default: ;
         endcase
      end
   end

   // data-cycle format registers, one per slot
   for (genvar i = 0; i < N_DCYC; i++) begin : g_dcyc
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            dcyc_q[i] <= '0;
         else if (wr_en && addr == OFS_DCYC + 8'(4 * i))
            dcyc_q[i] <= wdata & MSK_DCYC;
      end
   end

   assign sel_mask  = {ctrl_q[CB_SEL1], ctrl_q[CB_SEL0]};
   assign cfg_go_ok = (cfg0_q[3:2] & cfg1_q[3:2]) == 2'b00;

   always_comb begin
      rdata = '0;
      case (addr)
         OFS_SYSST: begin
            rdata[0] = 1'b1;
            rdata[8] = busy;
         end
         OFS_CTRL:   rdata[3:0] = ctrl_q;
         OFS_PIXCNT: rdata[CNT_W-1:0] = cnt;
         OFS_LINE:   rdata = line_q;
         OFS_RDDAT,
         OFS_RDSTS:  rdata[PANEL_W-1:0] = rxbuf;
         OFS_CFG0:   rdata = cfg0_q;
         OFS_CFG1:   rdata = cfg1_q;
         OFS_ONOFF0: rdata = onoff0_q;
         OFS_ONOFF1: rdata = onoff1_q;
         OFS_CYC0:   rdata = cyc0_q;
         OFS_CYC1:   rdata = cyc1_q;
         OFS_VSW:    rdata = vsw_q;
         OFS_HSW:    rdata = hsw_q;
         default: begin
            for (int i = 0; i < N_DCYC; i++)
               if (addr == OFS_DCYC + 8'(4 * i))
                  rdata = dcyc_q[i];
         end
      endcase
   end

   // R2
   ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == OFS_CTRL) |=> (rdata_ctrl_view() == $past(wdata[3:0])));

   function automatic logic [3:0] rdata_ctrl_view();
      return ctrl_q;
   endfunction

endmodule

// File: rtl/lcd_pbus_xfer.sv
module lcd_pbus_xfer #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic             start_req,
   input  logic             step,
   output logic             busy,
   output logic [CNT_W-1:0] cnt,
   output logic             frame_done
);

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic cnt_zero;
   assign cnt_zero = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt        <= '0;
         busy       <= 1'b0;
         frame_done <= 1'b0;
      end else begin
         frame_done <= 1'b0;
         if (cnt_wr) begin
            cnt <= cnt_wdata;
         end else if (step && !cnt_zero) begin
            cnt <= cnt - CNT_ONE;
            if (busy && cnt == CNT_ONE) begin
               busy       <= 1'b0;
               frame_done <= 1'b1;
            end
         end
         if (start_req && !busy && !cnt_zero)
            busy <= 1'b1;
      end
   end

   // R9
   done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> !busy);

   // R9
   done_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);

   // R9
   busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> frame_done);

   // R10
   zero_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && cnt_zero && !busy && !step) |=> (!busy && !frame_done));

endmodule

// File: rtl/lcd_pbus_seq.sv
module lcd_pbus_seq
   import lcd_pbus_pkg::*;
#(
   parameter int PANEL_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 launch,
   input  logic                 op_a0,
   input  logic                 op_rd,
   input  logic                 op_two,
   input  logic [N_PANEL-1:0]   op_cs,
   input  logic [2*PANEL_W-1:0] op_data,
   input  logic [PANEL_W-1:0]   pnl_din,
   output logic                 idle,
   output logic                 done,
   output logic [PANEL_W-1:0]   pnl_dout,
   output logic                 pnl_a0,
   output logic [N_PANEL-1:0]   pnl_cs,
   output logic                 pnl_wr,
   output logic                 pnl_rd,
   output logic [PANEL_W-1:0]   rxbuf
);

   sq_state_e            state;
   logic                 word_hi, two_q, rd_q, a0_q;
   logic [N_PANEL-1:0]   cs_q;
   logic [2*PANEL_W-1:0] buf_q;
   logic                 strobe;

   assign strobe   = (state == SQ_STRB);
   assign idle     = (state == SQ_IDLE);
   assign done     = (state == SQ_HOLD) && (word_hi || !two_q);
   assign pnl_dout = word_hi ? buf_q[2*PANEL_W-1:PANEL_W] : buf_q[PANEL_W-1:0];
   assign pnl_a0   = a0_q;
   assign pnl_wr   = strobe && !rd_q;
   assign pnl_rd   = strobe && rd_q;

   for (genvar p = 0; p < N_PANEL; p++) begin : g_cs
      assign pnl_cs[p] = strobe && cs_q[p];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SQ_IDLE;
         word_hi <= 1'b0;
         two_q   <= 1'b0;
         rd_q    <= 1'b0;
         a0_q    <= 1'b0;
         cs_q    <= '0;
         buf_q   <= '0;
         rxbuf   <= '0;
      end else begin
         case (state)
            SQ_IDLE: if (launch) begin
               word_hi <= 1'b0;
               two_q   <= op_two;
               rd_q    <= op_rd;
               a0_q    <= op_a0;
               cs_q    <= op_cs;
               buf_q   <= op_data;
               state   <= SQ_SETUP;
            end
            SQ_SETUP: state <= SQ_STRB;
            SQ_STRB: begin
               if (rd_q && |cs_q)
                  rxbuf <= pnl_din;
               state <= SQ_HOLD;
            end
            SQ_HOLD: begin
               if (done) begin
                  state <= SQ_IDLE;
               end else begin
                  word_hi <= 1'b1;
                  state   <= SQ_SETUP;
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   // R11
   setup_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> ($stable(pnl_dout) && $stable(pnl_a0)));

   // R11
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_HOLD) |-> ($stable(pnl_dout) && $stable(pnl_a0)));

   // R11
   strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pnl_wr || pnl_rd) |=> !(pnl_wr || pnl_rd));

   // R6
   rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pnl_rd |-> $onehot0(pnl_cs));

endmodule

// File: rtl/lcd_pbus_ctrl.sv
module lcd_pbus_ctrl
   import lcd_pbus_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int PANEL_W = 16,
   parameter int CNT_W   = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic               bus_ready,
   output logic [PANEL_W-1:0] pnl_dout,
   input  logic [PANEL_W-1:0] pnl_din,
   output logic               pnl_a0,
   output logic [1:0]         pnl_cs,
   output logic               pnl_wr,
   output logic               pnl_rd,
   output logic               frame_done
);

   localparam int PAIR_W = 2 * PANEL_W;

   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must be at least 8");
   end
   if (PANEL_W < 1 || PAIR_W > REG_W) begin : g_bad_panel
      $error("PANEL_W must be between 1 and 16");
   end
   if (CNT_W < 1 || CNT_W > REG_W) begin : g_bad_cnt
      $error("CNT_W must be between 1 and 32");
   end

   logic [7:0] addr8;
   logic       hi_ok;
   assign addr8 = bus_addr[7:0];

   if (ADDR_W > 8) begin : g_hi_dec
      assign hi_ok = ~|bus_addr[ADDR_W-1:8];
   end else begin : g_hi_none
      assign hi_ok = 1'b1;
   end

   pop_e               pop;
   logic               panel_op, seq_idle, seq_done, launch, step;
   logic               reg_we, start_req, cnt_wr;
   logic [1:0]         sel_mask;
   logic               cfg_go_ok, busy;
   logic [CNT_W-1:0]   cnt;
   logic [PANEL_W-1:0] rxbuf;
   logic [31:0]        rd_int;
   logic [1:0]         op_cs;
   logic               op_rd;

   always_comb begin
      pop = POP_NONE;
      if (bus_sel && bus_wr && hi_ok) begin
         case (addr8)
            OFS_CMD:   pop = POP_CMD;
            OFS_PARM:  pop = POP_PARM;
            OFS_PIX:   pop = POP_PIX;
            OFS_RDDAT: pop = POP_RDD;
            OFS_RDSTS: pop = POP_RDS;
            default:   pop = POP_NONE;
         endcase
      end
   end

   assign panel_op = (pop != POP_NONE);
   assign launch   = panel_op && seq_idle;
   assign op_rd    = (pop == POP_RDD) || (pop == POP_RDS);
   assign op_cs    = !op_rd       ? sel_mask :
                     sel_mask[0]  ? 2'b01    :
                     sel_mask[1]  ? 2'b10    : 2'b00;
   assign bus_ready = !panel_op || seq_done;
   assign step      = panel_op && seq_done && (pop == POP_PIX || op_rd);

   assign reg_we    = bus_sel && bus_wr && hi_ok && !panel_op;
   assign start_req = reg_we && addr8 == OFS_CTRL && bus_wdata[CB_GO] &&
                      bus_wdata[CB_EN] && !bus_wdata[CB_BYP] && cfg_go_ok;
   assign cnt_wr    = reg_we && addr8 == OFS_PIXCNT;
   assign bus_rdata = hi_ok ? rd_int : '0;

   lcd_pbus_regs #(.CNT_W(CNT_W), .PANEL_W(PANEL_W)) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_we),
      .addr      (addr8),
      .wdata     (bus_wdata),
      .busy      (busy),
      .cnt       (cnt),
      .rxbuf     (rxbuf),
      .sel_mask  (sel_mask),
      .cfg_go_ok (cfg_go_ok),
      .rdata     (rd_int)
   );

   lcd_pbus_seq #(.PANEL_W(PANEL_W)) seq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch   (launch),
      .op_a0    (!(pop == POP_CMD || pop == POP_RDS)),
      .op_rd    (op_rd),
      .op_two   (pop == POP_PIX),
      .op_cs    (op_cs),
      .op_data  (bus_wdata[PAIR_W-1:0]),
      .pnl_din  (pnl_din),
      .idle     (seq_idle),
      .done     (seq_done),
      .pnl_dout (pnl_dout),
      .pnl_a0   (pnl_a0),
      .pnl_cs   (pnl_cs),
      .pnl_wr   (pnl_wr),
      .pnl_rd   (pnl_rd),
      .rxbuf    (rxbuf)
   );

   lcd_pbus_xfer #(.CNT_W(CNT_W)) xfer_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cnt_wr     (cnt_wr),
      .cnt_wdata  (bus_wdata[CNT_W-1:0]),
      .start_req  (start_req),
      .step       (step),
      .busy       (busy),
      .cnt        (cnt),
      .frame_done (frame_done)
   );

   // R12
   launch_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> !bus_ready);

   // R12
   strobe_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pnl_wr || pnl_rd) |-> (panel_op && !bus_ready));

endmodule

// File: tb/lcd_pbus_ctrl_tb.sv
`timescale 1ns/1ps
module lcd_pbus_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_ready;
   logic [15:0] pnl_dout, pnl_din;
   logic        pnl_a0, pnl_wr, pnl_rd, frame_done;
   logic [1:0]  pnl_cs;

   always #2 clk = ~clk;

   lcd_pbus_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_ready(bus_ready), .pnl_dout(pnl_dout), .pnl_din(pnl_din),
      .pnl_a0(pnl_a0), .pnl_cs(pnl_cs), .pnl_wr(pnl_wr), .pnl_rd(pnl_rd),
      .frame_done(frame_done)
   );

   // panel models: panel 0 answers 0xA00x, panel 1 answers 0xB00x (x = A0)
   assign pnl_din = !pnl_rd    ? 16'h0000 :
                    pnl_cs[0]  ? (16'hA000 | {15'b0, pnl_a0}) :
                    pnl_cs[1]  ? (16'hB000 | {15'b0, pnl_a0}) : 16'hEEEE;

   int nchk = 0, nfail = 0;
   logic [1:0]  log_cs [16];
   logic        log_a0 [16];
   logic [15:0] log_d  [16];
   int          log_n = 0;
   int          stab_err = 0, done_cnt = 0;
   logic        hold_pend = 1'b0;
   logic [15:0] prev_d = '0, hold_d = '0;
   logic        prev_a0 = 1'b0, hold_a0 = 1'b0;
   logic [1:0]  rd_cs = '0;
   logic        rd_a0 = 1'b0;

   always @(negedge clk) begin
      if (frame_done) done_cnt++;
      if (pnl_wr || pnl_rd) begin
         if (pnl_dout !== prev_d || pnl_a0 !== prev_a0) stab_err++;
         hold_pend = 1'b1;
         hold_d    = pnl_dout;
         hold_a0   = pnl_a0;
      end else if (hold_pend) begin
         if (pnl_dout !== hold_d || pnl_a0 !== hold_a0) stab_err++;
         hold_pend = 1'b0;
      end
      if (pnl_wr && log_n < 16) begin
         log_cs[log_n] = pnl_cs;
         log_a0[log_n] = pnl_a0;
         log_d[log_n]  = pnl_dout;
         log_n++;
      end
      if (pnl_rd) begin
         rd_cs = pnl_cs;
         rd_a0 = pnl_a0;
      end
      prev_d  = pnl_dout;
      prev_a0 = pnl_a0;
   end

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: got %h expected %h", rq, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d, output int waits);
      waits = 0;
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      #1;
      while (!bus_ready) begin
         waits++;
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic chk_log(input string rq, input int idx, input logic [1:0] cs,
                          input logic a0, input logic [15:0] d);
      if (idx >= log_n) begin
         chk(rq, 32'(log_n), 32'(idx + 1));
      end else begin
         chk(rq, {13'b0, log_cs[idx], log_a0[idx], log_d[idx]}, {13'b0, cs, a0, d});
      end
   endtask

   // {offset, write value, expected read-back}
   localparam int NV = 12;
   localparam logic [71:0] VECS [NV] = '{
      {8'h04, 32'hFFFF_FFF0, 32'h0000_0000},   // R2 control keeps 3:0, no start
      {8'h04, 32'h0000_000D, 32'h0000_000D},   // R2
      {8'h24, 32'hFFFF_FFFF, 32'h003F_1FFF},   // R2 config 0
      {8'h28, 32'h1234_5678, 32'h0034_1678},   // R2 config 1
      {8'h2C, 32'hFFFF_FFFF, 32'h3FFF_FFFF},   // R2 on/off time
      {8'h30, 32'hFFFF_FFFF, 32'h0FFF_FFFF},   // R2 cycle time
      {8'h44, 32'hFFFF_FFFF, 32'h0F1F_0F1F},   // R2 data cycle
      {8'h54, 32'hABCD_EF01, 32'h0000_EF01},   // R2 sync width
      {8'h0C, 32'hFFFF_FFFF, 32'h0000_07FF},   // R2 line number
      {8'h08, 32'hFFFF_FFFF, 32'h00FF_FFFF},   // R2 pixel counter
      {8'h00, 32'hFFFF_FFFF, 32'h0000_0001},   // R13 status write ignored
      {8'h5C, 32'hFFFF_FFFF, 32'h0000_0000}    // R13 unmapped
   };

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      logic [31:0] rv;
      int w, base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      bus_read(8'h04, rv); chk("R1 ctrl", rv, 32'h2);
      bus_read(8'h24, rv); chk("R1 cfg0", rv, 32'h0031_0000);
      bus_read(8'h28, rv); chk("R1 cfg1", rv, 32'h0031_0000);
      bus_read(8'h08, rv); chk("R1 pixcnt", rv, 32'h0);
      bus_read(8'h1C, rv); chk("R1 rxbuf", rv, 32'h0);
      bus_read(8'h00, rv); chk("R1 R7 status", rv, 32'h1);
      chk("R1 strobes", {29'b0, pnl_cs, frame_done}, 32'h0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         bus_write(VECS[i][71:64], VECS[i][63:32], w);
         chk("R12 reg write no stall", 32'(w), 32'd0);
         bus_read(VECS[i][71:64], rv);
         chk(i >= 10 ? "R13 vector" : "R2 vector", rv, VECS[i][31:0]);
      end

      // clear configs so starts are allowed
      bus_write(8'h24, 32'h0, w);
      bus_write(8'h28, 32'h0, w);

      // R3 command to panel 0 only
      bus_write(8'h04, 32'h5, w);
      bus_write(8'h10, 32'h0001_A5C3, w);
      chk("R12 one-word stall", 32'(w), 32'd3);
      chk_log("R3 command word", 0, 2'b01, 1'b0, 16'hA5C3);

      // R4 parameter to both panels
      bus_write(8'h04, 32'hD, w);
      bus_write(8'h14, 32'h0000_1234, w);
      chk_log("R4 R3 parameter both panels", 1, 2'b11, 1'b1, 16'h1234);

      // R8 start and R7 busy
      bus_write(8'h08, 32'd2, w);
      bus_write(8'h04, 32'h1D, w);
      bus_read(8'h00, rv); chk("R7 R8 busy after start", rv, 32'h101);
      bus_read(8'h04, rv); chk("R2 go bit not kept", rv, 32'hD);

      // R5 pixel write
      bus_write(8'h18, 32'hBEEF_CAFE, w);
      chk("R12 two-word stall", 32'(w), 32'd6);
      chk_log("R5 low half first", 2, 2'b11, 1'b1, 16'hCAFE);
      chk_log("R5 high half second", 3, 2'b11, 1'b1, 16'hBEEF);
      bus_read(8'h08, rv); chk("R5 counter step", rv, 32'd1);

      // R6 data read with panel 0 priority; R9 completes transfer
      bus_write(8'h1C, 32'h0, w);
      #1;
      chk("R9 frame_done pulse", {31'b0, frame_done}, 32'h1);
      bus_read(8'h00, rv); chk("R9 busy cleared", rv, 32'h1);
      @(negedge clk); #1;
      chk("R9 pulse one cycle", {31'b0, frame_done}, 32'h0);
      bus_read(8'h1C, rv); chk("R6 data read panel 0", rv, 32'hA001);
      chk("R6 read strobe target", {30'b0, rd_cs}, 32'h1);

      // R6 status read from panel 1
      bus_write(8'h04, 32'h9, w);
      bus_write(8'h20, 32'h0, w);
      bus_read(8'h20, rv); chk("R6 status read panel 1", rv, 32'hB000);
      chk("R6 status read A0 low", {31'b0, rd_a0}, 32'h0);
      bus_read(8'h08, rv); chk("R6 counter floor", rv, 32'h0);

      // R6 read with no panel keeps buffer
      bus_write(8'h04, 32'h1, w);
      bus_write(8'h1C, 32'h0, w);
      bus_read(8'h1C, rv); chk("R6 no panel keeps buffer", rv, 32'hB000);

      // R10 zero count start
      base = done_cnt;
      bus_write(8'h04, 32'h15, w);
      repeat (3) @(negedge clk);
      bus_read(8'h00, rv); chk("R10 no busy", rv, 32'h1);
      chk("R10 no pulse", 32'(done_cnt - base), 32'd0);

      // R8 blocked starts
      bus_write(8'h08, 32'd3, w);
      bus_write(8'h04, 32'h17, w);
      bus_read(8'h00, rv); chk("R8 bypass blocks", rv, 32'h1);
      bus_write(8'h24, 32'hC, w);
      bus_write(8'h28, 32'hC, w);
      bus_write(8'h04, 32'h15, w);
      bus_read(8'h00, rv); chk("R8 config both set blocks", rv, 32'h1);
      bus_write(8'h28, 32'h4, w);
      bus_write(8'h04, 32'h15, w);
      bus_read(8'h00, rv); chk("R8 config bit 2 common blocks", rv, 32'h1);
      bus_write(8'h28, 32'h3, w);
      bus_write(8'h04, 32'h14, w);
      bus_read(8'h00, rv); chk("R8 disabled blocks", rv, 32'h1);
      bus_write(8'h04, 32'h15, w);
      bus_read(8'h00, rv); chk("R8 start allowed", rv, 32'h101);

      // R9 three-pixel transfer on panel 0
      base = done_cnt;
      bus_write(8'h18, 32'h0002_0001, w);
      bus_write(8'h18, 32'h0004_0003, w);
      chk("R9 no early pulse", 32'(done_cnt - base), 32'd0);
      bus_write(8'h18, 32'h0006_0005, w);
      #1;
      chk("R9 pulse at last pixel", {31'b0, frame_done}, 32'h1);
      for (int k = 0; k < 6; k++)
         chk_log("R5 pixel order", 4 + k, 2'b01, 1'b1, 16'(k + 1));
      @(negedge clk);
      chk("R9 single pulse", 32'(done_cnt - base), 32'd1);

      // R11 framing of every strobe seen
      chk("R11 setup/hold stable", 32'(stab_err), 32'd0);
      chk("R11 strobe count", 32'(log_n), 32'd10);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule